// File: doc/BRIEF.md
# Speculative Load Address Tracker

This block keeps a small table of loads that software has moved ahead of stores whose addresses were unknown when the code was scheduled. When such an early load issues, the table records the destination register number together with the byte range it read. Each later store is compared in parallel against every live record. Any record whose bytes overlap the store's bytes is dropped, because the early value may now be stale.

Before the early value is used, a verifying operation asks the table about the destination register. If a live record for that register remains, the early value is still good. If no record remains, a verifying load is told to reissue the load. A verifying branch is told to jump to recovery code instead. Either kind of query can also remove the record it finds.

The table is fully associative on register number. It holds a parameterised number of records and picks a victim by rotation once every slot is in use. A flush input empties it. Each query result appears on registered outputs one cycle after the query.

Top module: `slt_table`

## Requirements
- R1: After reset, no record is live: every query misses, and `rsp_valid` stays low until a query is made.
- R2: A load recorded for a register makes a later query on that register hit. A query with `chk_mode[0]`=0 leaves the record in place, so a repeated query hits again.
- R3: A query with `chk_mode[0]`=1 that hits removes the record, so the next query on that register misses.
- R4: A store invalidates every record whose byte range overlaps its own, including a partial overlap. Sizes are coded as 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes, starting at the given address.
- R5: A store whose byte range does not overlap a record leaves that record live, even when the two ranges are adjacent.
- R6: On a miss, a load query (`chk_mode[1]`=0) raises only `rsp_reload` and a branch query (`chk_mode[1]`=1) raises only `rsp_recover`. On a hit, only `rsp_hit` is raised.
- R7: A new load to a register that already has a record replaces that record's address. A register never holds more than one record.
- R8: When every slot holds a different register, a load to a new register evicts records by rotation. The first such eviction after reset or flush takes the first register recorded into an empty table, and the next eviction takes the second.
- R9: A store and a query in the same cycle are resolved with the store first, so an overlapping store makes that query miss.
- R10: Asserting `flush` removes every record.
- R11: The outcome of a query made in one cycle is on the outputs in the next cycle, with `rsp_valid` high for exactly that cycle.
- R12: A load recorded in the same cycle as an overlapping store is kept, because recording takes effect after snooping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Remove all records |
| ld_valid | input | 1 | Record an early load this cycle |
| ld_reg | input | REG_W | Destination register of the early load |
| ld_addr | input | ADDR_W | First byte address of the early load |
| ld_size | input | 2 | Size code of the early load |
| st_valid | input | 1 | A store is snooped this cycle |
| st_addr | input | ADDR_W | First byte address of the store |
| st_size | input | 2 | Size code of the store |
| chk_valid | input | 1 | A query is made this cycle |
| chk_reg | input | REG_W | Register being queried |
| chk_mode | input | 2 | Bit 0 removes the record on a hit; bit 1 selects a branch query |
| rsp_valid | output | 1 | Query outcome valid |
| rsp_hit | output | 1 | Record was live; the early value stands |
| rsp_reload | output | 1 | Load query missed; the load must be reissued |
| rsp_recover | output | 1 | Branch query missed; take the recovery path |

## Verification
Stores are tried at several distances from a recorded range: straddling its lower edge, touching either edge without crossing it, and falling one byte inside it. This separates a correct byte-range comparison from one that compares only start addresses or is off by one at the end. Queries are issued in all four modes on both live and missing registers, which shows that removal and the choice between reload and recovery follow the mode bits. Filling the table with distinct registers and then overflowing it shows the rotation order. Same-cycle store, query and load combinations show the order in which the three act.

// File: rtl/slt_pkg.sv
package slt_pkg;

    // Access size codes: number of bytes is 1 << code
    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } size_code_e;

    // Query modes: bit 0 = remove on hit, bit 1 = branch flavour
    typedef enum logic [1:0] {
        CHK_LD_KEEP = 2'd0,
        CHK_LD_DROP = 2'd1,
        CHK_BR_KEEP = 2'd2,
        CHK_BR_DROP = 2'd3
    } chk_mode_e;

    localparam int unsigned CMP_W = 65;

    function automatic logic [3:0] span_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

    // Half-open byte ranges [a, a+len) and [b, b+len) intersect
    function automatic logic ranges_overlap(
        input logic [63:0] a_base,
        input logic [1:0]  a_code,
        input logic [63:0] b_base,
        input logic [1:0]  b_code
    );
        logic [CMP_W-1:0] a_lo, a_hi, b_lo, b_hi;
        a_lo = {1'b0, a_base};
        b_lo = {1'b0, b_base};
        a_hi = a_lo + CMP_W'(span_bytes(a_code));
        b_hi = b_lo + CMP_W'(span_bytes(b_code));
        return (a_lo < b_hi) && (b_lo < a_hi);
    endfunction

    function automatic logic mode_is_branch(input chk_mode_e m);
        return (m == CHK_BR_KEEP) || (m == CHK_BR_DROP);
    endfunction

    function automatic logic mode_drops(input chk_mode_e m);
        return (m == CHK_LD_DROP) || (m == CHK_BR_DROP);
    endfunction

endpackage

// File: rtl/slt_entry.sv
module slt_entry
    import slt_pkg::*;
#(
    parameter int unsigned REG_W  = 7,
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_reg,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_size,
    input  logic              clr_en,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    output logic              valid_o,
    output logic [REG_W-1:0]  reg_o,
    output logic              kill_o
);

    typedef struct packed {
        logic              vld;
        logic [REG_W-1:0]  rnum;
        logic [ADDR_W-1:0] addr;
        size_code_e        size;
    } rec_t;

    rec_t rec_q;

    // Snoop: live record overlapped by the store in flight
    assign kill_o = rec_q.vld && st_valid &&
                    ranges_overlap(64'(rec_q.addr), rec_q.size,
                                   64'(st_addr), st_size);

    assign valid_o = rec_q.vld;
    assign reg_o   = rec_q.rnum;

    // Write beats snoop kill and query removal in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
        end else if (flush) begin
            rec_q.vld <= 1'b0;
        end else if (wr_en) begin
            rec_q.vld  <= 1'b1;
            rec_q.rnum <= wr_reg;
            rec_q.addr <= wr_addr;
            rec_q.size <= size_code_e'(wr_size);
        end else if (kill_o || clr_en) begin
            rec_q.vld <= 1'b0;
        end
    end

endmodule

// File: rtl/slt_alloc.sv
module slt_alloc #(
    parameter int unsigned NUM_ENTRIES = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  logic                   alloc,
    input  logic [NUM_ENTRIES-1:0] valid_vec,
    input  logic [NUM_ENTRIES-1:0] match_vec,
    output logic [NUM_ENTRIES-1:0] wr_vec
);

    localparam int unsigned PTR_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_ENTRIES - 1);

    logic [PTR_W-1:0] ptr_q;
    logic             evict;
    logic             found;

    // Same register first, then lowest empty slot, then rotation victim
    always_comb begin
        wr_vec = '0;
        evict  = 1'b0;
        found  = 1'b0;
        if (alloc) begin
            if (|match_vec) begin
                wr_vec = match_vec;
            end else if (!(&valid_vec)) begin
                for (int i = 0; i < NUM_ENTRIES; i++) begin
                    if (!valid_vec[i] && !found) begin
                        wr_vec[i] = 1'b1;
                        found     = 1'b1;
                    end
                end
            end else begin
                wr_vec[ptr_q] = 1'b1;
                evict         = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ptr_q <= '0;
        end else if (evict) begin
            ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/slt_table.sv
module slt_table
    import slt_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 16,
    parameter int unsigned REG_W       = 7,
    parameter int unsigned ADDR_W      = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              ld_valid,
    input  logic [REG_W-1:0]  ld_reg,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [1:0]        ld_size,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic              chk_valid,
    input  logic [REG_W-1:0]  chk_reg,
    input  logic [1:0]        chk_mode,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_reload,
    output logic              rsp_recover
);

    logic [NUM_ENTRIES-1:0] valid_vec;
    logic [NUM_ENTRIES-1:0] kill_vec;
    logic [NUM_ENTRIES-1:0] hit_vec;
    logic [NUM_ENTRIES-1:0] ld_match_vec;
    logic [NUM_ENTRIES-1:0] wr_vec;
    logic [NUM_ENTRIES-1:0] clr_vec;
    logic [REG_W-1:0]       reg_arr [NUM_ENTRIES];

    chk_mode_e mode;
    logic      query_drop;
    logic      query_branch;
    logic      query_live;

    assign mode         = chk_mode_e'(chk_mode);
    assign query_drop   = chk_valid && mode_drops(mode);
    assign query_branch = mode_is_branch(mode);
    // Store snoop resolves before the query: killed records do not hit
    assign query_live   = |(hit_vec & ~kill_vec);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        assign hit_vec[g]      = valid_vec[g] && (reg_arr[g] == chk_reg);
        assign ld_match_vec[g] = valid_vec[g] && (reg_arr[g] == ld_reg);
        assign clr_vec[g]      = query_drop && hit_vec[g];

        slt_entry #(
            .REG_W  (REG_W),
            .ADDR_W (ADDR_W)
        ) u_entry (
            .clk      (clk),
            .rst      (rst),
            .flush    (flush),
            .wr_en    (wr_vec[g]),
            .wr_reg   (ld_reg),
            .wr_addr  (ld_addr),
            .wr_size  (ld_size),
            .clr_en   (clr_vec[g]),
            .st_valid (st_valid),
            .st_addr  (st_addr),
            .st_size  (st_size),
            .valid_o  (valid_vec[g]),
            .reg_o    (reg_arr[g]),
            .kill_o   (kill_vec[g])
        );
    end

    slt_alloc #(
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_alloc (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .alloc     (ld_valid && !flush),
        .valid_vec (valid_vec),
        .match_vec (ld_match_vec),
        .wr_vec    (wr_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_reload  <= 1'b0;
            rsp_recover <= 1'b0;
        end else begin
            rsp_valid   <= chk_valid;
            rsp_hit     <= chk_valid && query_live;
            rsp_reload  <= chk_valid && !query_live && !query_branch;
            rsp_recover <= chk_valid && !query_live && query_branch;
        end
    end

endmodule

// File: rtl/slt_checker.sv
module slt_checker #(
    parameter int unsigned N = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         flush,
    input logic         chk_valid,
    input logic [1:0]   chk_mode,
    input logic         rsp_valid,
    input logic         rsp_hit,
    input logic         rsp_reload,
    input logic         rsp_recover,
    input logic [N-1:0] valid_vec,
    input logic [N-1:0] hit_vec
);

    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_vec == '0));

    a_r11_rsp_follows_query: assert property (@(posedge clk) disable iff (rst)
        chk_valid |=> rsp_valid);

    a_r11_rsp_quiet: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |=> !rsp_valid);

    a_r6_single_outcome: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones({rsp_hit, rsp_reload, rsp_recover}) == 1));

    a_r6_branch_no_reload: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && chk_mode[1]) |=> !rsp_reload);

    a_r6_load_no_recover: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && !chk_mode[1]) |=> !rsp_recover);

    a_r7_one_record_per_reg: assert property (@(posedge clk) disable iff (rst)
        chk_valid |-> $onehot0(hit_vec));

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0));

endmodule

bind slt_table slt_checker #(.N(NUM_ENTRIES)) u_slt_checker (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .chk_valid   (chk_valid),
    .chk_mode    (chk_mode),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_reload  (rsp_reload),
    .rsp_recover (rsp_recover),
    .valid_vec   (valid_vec),
    .hit_vec     (hit_vec)
);

// File: tb/tb_slt_table.sv
module tb_slt_table;

    localparam int unsigned NE  = 16;
    localparam int unsigned RW  = 7;
    localparam int unsigned AW  = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          flush;
    logic          ld_valid;
    logic [RW-1:0] ld_reg;
    logic [AW-1:0] ld_addr;
    logic [1:0]    ld_size;
    logic          st_valid;
    logic [AW-1:0] st_addr;
    logic [1:0]    st_size;
    logic          chk_valid;
    logic [RW-1:0] chk_reg;
    logic [1:0]    chk_mode;
    logic          rsp_valid, rsp_hit, rsp_reload, rsp_recover;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    slt_table #(.NUM_ENTRIES(NE), .REG_W(RW), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .flush(flush),
        .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_addr(ld_addr), .ld_size(ld_size),
        .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
        .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_mode(chk_mode),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_reload(rsp_reload), .rsp_recover(rsp_recover)
    );

    task automatic expect_eq(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_all();
        flush = 0; ld_valid = 0; st_valid = 0; chk_valid = 0;
    endtask

    task automatic step();
        @(negedge clk);
        idle_all();
    endtask

    task automatic set_load(input int r, input int a, input int sz);
        ld_valid = 1; ld_reg = RW'(r); ld_addr = AW'(a); ld_size = 2'(sz);
    endtask

    task automatic set_store(input int a, input int sz);
        st_valid = 1; st_addr = AW'(a); st_size = 2'(sz);
    endtask

    task automatic set_query(input int r, input int m);
        chk_valid = 1; chk_reg = RW'(r); chk_mode = 2'(m);
    endtask

    // Outcome expected from the mode and whether a record should be live
    task automatic expect_outcome(input string req, input int m, input logic live);
        logic is_br;
        is_br = m[1];
        expect_eq(req, "rsp_valid", 32'(rsp_valid), 32'd1);
        expect_eq(req, "rsp_hit", 32'(rsp_hit), 32'(live));
        expect_eq(req, "rsp_reload", 32'(rsp_reload), 32'(!live && !is_br));
        expect_eq(req, "rsp_recover", 32'(rsp_recover), 32'(!live && is_br));
    endtask

    task automatic query(input string req, input int r, input int m, input logic live);
        set_query(r, m);
        step();
        expect_outcome(req, m, live);
    endtask

    task automatic load(input int r, input int a, input int sz);
        set_load(r, a, sz);
        step();
    endtask

    task automatic store(input int a, input int sz);
        set_store(a, sz);
        step();
    endtask

    task automatic t_reset();
        expect_eq("R1", "rsp_valid idle after reset", 32'(rsp_valid), 32'd0);
        query("R1", 5, 0, 1'b0);
        query("R1", 0, 2, 1'b0);
    endtask

    task automatic t_keep_and_drop();
        load(10, 'h100, 2);
        query("R2", 10, 0, 1'b1);
        query("R2", 10, 2, 1'b1);
        query("R3", 10, 1, 1'b1);
        query("R3", 10, 0, 1'b0);
        load(13, 'h180, 0);
        query("R3", 13, 3, 1'b1);
        query("R3", 13, 2, 1'b0);
    endtask

    task automatic t_overlap();
        load(11, 'h200, 3);
        store('h1FE, 2);
        query("R4", 11, 0, 1'b0);
        load(12, 'h300, 1);
        store('h2FF, 0);
        store('h302, 2);
        store('h2FC, 2);
        query("R5", 12, 0, 1'b1);
        store('h301, 0);
        query("R4", 12, 0, 1'b0);
        load(14, 'h400, 2);
        store('h3F8, 3);
        query("R5", 14, 0, 1'b1);
        store('h3F9, 3);
        query("R4", 14, 0, 1'b0);
    endtask

    task automatic t_kinds();
        query("R6", 50, 2, 1'b0);
        query("R6", 50, 0, 1'b0);
        query("R6", 50, 3, 1'b0);
        load(50, 'h900, 0);
        query("R6", 50, 2, 1'b1);
    endtask

    task automatic t_replace();
        load(20, 'h1400, 0);
        load(20, 'h1500, 0);
        store('h1400, 0);
        query("R7", 20, 0, 1'b1);
        store('h1500, 0);
        query("R7", 20, 0, 1'b0);
    endtask

    task automatic t_same_cycle();
        load(21, 'h600, 2);
        set_store('h602, 0);
        set_query(21, 0);
        step();
        expect_outcome("R9", 0, 1'b0);
        set_load(22, 'h700, 2);
        set_store('h700, 2);
        step();
        query("R12", 22, 0, 1'b1);
    endtask

    task automatic t_flush_timing();
        load(30, 'hA00, 0);
        load(31, 'hB00, 0);
        set_query(30, 0);
        step();
        expect_outcome("R11", 0, 1'b1);
        step();
        expect_eq("R11", "rsp_valid one cycle only", 32'(rsp_valid), 32'd0);
        flush = 1;
        step();
        query("R10", 30, 0, 1'b0);
        query("R10", 31, 2, 1'b0);
    endtask

    task automatic t_rotation();
        flush = 1;
        step();
        for (int i = 0; i < NE; i++) load(40 + i, 'h2000 + 16 * i, 0);
        load(40 + NE, 'h3000, 0);
        query("R8", 40, 0, 1'b0);
        query("R8", 41, 0, 1'b1);
        query("R8", 40 + NE, 0, 1'b1);
        load(41 + NE, 'h3100, 0);
        query("R8", 41, 0, 1'b0);
        query("R8", 42, 0, 1'b1);
        query("R8", 41 + NE, 0, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog run did not finish actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_all();
        ld_reg = '0; ld_addr = '0; ld_size = '0;
        st_addr = '0; st_size = '0; chk_reg = '0; chk_mode = '0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_keep_and_drop();
        t_overlap();
        t_kinds();
        t_replace();
        t_same_cycle();
        t_flush_timing();
        t_rotation();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule